// File: doc/BRIEF.md
# Transmit Audio Interrupt Generator

This block builds the interrupt status of one audio transmit channel from the flags reported by its FIFO. It keeps a three-bit raw status vector and a software enable mask. It drives one level-sensitive interrupt line, which is high while any enabled raw bit is set. The underrun source is sticky. Once an underrun event is seen, its bit stays set until software writes the clear register with the underrun-clear bit set. The transmit-request source follows the half-empty flag. The transmit-done source is set only while the FIFO is empty and the channel is idle.

The register side uses a simple word interface: a write strobe with an address and data, and a separate combinational read address. The status register samples the FIFO flags on every clock edge. Every register write and every drain event is therefore reflected one cycle later. The interrupt line is recomputed at once from the registered status and the mask.

The underrun source is a two-state machine. In `UR_IDLE` no underrun is pending. It moves to `UR_HELD` on an underrun event. It returns to `UR_IDLE` on a clear write carrying the underrun-clear bit, but only if no new underrun arrives in that same cycle. In every other case it stays where it is.

Top module: `aud_irq_gen`

## Requirements
- R1: Raw status bit 0 (transmit request) equals the half-empty input sampled at the previous clock edge.
- R2: Raw status bit 1 (transmit done) is 1 in a cycle only if, at the previous edge, the empty input was 1 and the busy input was 0; otherwise it is 0.
- R3: Raw status bit 2 (underrun) is set one cycle after the underrun input is high, and it then stays set while no clear is written.
- R4: A write of the clear register (address 2) with data bit 2 set clears raw bit 2 at that edge. A clear write with data bit 2 at 0 leaves it unchanged.
- R5: If a clear write with bit 2 set and a high underrun input occur in the same cycle, raw bit 2 stays set.
- R6: During and right after reset, the raw status, the enable mask and the interrupt output are all 0.
- R7: The interrupt output is 1 exactly when the bitwise AND of the raw status and the enable mask is nonzero.
- R8: Reads return the raw status limited to its low 7 bits at address 0, the enable mask at address 1 (written through address 1, bits 2:0), 0 at address 2, and the raw status ANDed with the mask at address 3.
- R9: Writes to address 0 or address 3 change neither the mask nor the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_half_i | input | 1 | FIFO at or below half full |
| tx_empty_i | input | 1 | FIFO empty |
| tx_busy_i | input | 1 | Channel still shifting data |
| tx_urun_i | input | 1 | Underrun event from the FIFO side |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Read address |
| reg_rdata_o | output | DATA_W | Read data for reg_raddr_i |
| raw_stat_o | output | 3 | Raw interrupt status {underrun, done, request} |
| irq_o | output | 1 | Masked interrupt line |

## Verification
A wrong underrun state shows up at raw_stat_o bit 2 and on the address-0 read in the cycle after the edge that caused it. Examples are a lost sticky bit, a clear that wins over a new event, and a clear that ignores its data bit. Because irq_o is combinational from the status and the mask, a corrupted mask or wrong masking logic shows on irq_o in the same cycle as the faulty mask write takes effect. A mismatch between a flag and its status bit appears exactly one edge after the flag changes.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
    localparam int STAT_W   = 3;
    localparam int VIEW_W   = 7;
    localparam int BIT_REQ  = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_URUN = 2;

    localparam logic [1:0] A_RAW  = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_CLR  = 2'd2;
    localparam logic [1:0] A_PEND = 2'd3;

    typedef enum logic {
        UR_IDLE = 1'b0,
        UR_HELD = 1'b1
    } ur_state_e;
endpackage

// File: rtl/aud_irq_src.sv
module aud_irq_src
    import aud_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_i,
    input  logic              empty_i,
    input  logic              busy_i,
    input  logic              urun_i,
    input  logic              clr_urun_i,
    output logic [STAT_W-1:0] raw_o
);
    ur_state_e state_q, state_d;
    logic      req_q, done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UR_IDLE;
        else        state_q <= state_d;
    end

    // next state: a fresh underrun outranks a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UR_IDLE: if (urun_i) state_d = UR_HELD;
            UR_HELD: if (clr_urun_i && !urun_i) state_d = UR_IDLE;
        endcase
    end

    // level sources sampled every edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            req_q  <= half_i;
            done_q <= empty_i & ~busy_i;
        end
    end

    always_comb begin
        raw_o           = '0;
        raw_o[BIT_REQ]  = req_q;
        raw_o[BIT_DONE] = done_q;
        raw_o[BIT_URUN] = (state_q == UR_HELD);
    end
endmodule

// File: rtl/aud_irq_regs.sv
module aud_irq_regs
    import aud_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic [STAT_W-1:0] raw_i,
    output logic [STAT_W-1:0] mask_o,
    output logic              clr_urun_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] pend;
    logic [DATA_W-1:0] raw_ext, view_keep;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:STAT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_i && waddr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[STAT_W-1:0];
    end

    assign clr_urun_o = wr_i && (waddr_i == ADDR_W'(A_CLR)) && wdata_i[BIT_URUN];

    for (genvar g = 0; g < STAT_W; g++) begin : g_pend
        assign pend[g] = raw_i[g] & mask_q[g];
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_view
        assign view_keep[g] = (g < VIEW_W);
    end

    assign raw_ext = {{PAD_W{1'b0}}, raw_i};

    always_comb begin
        unique case (raddr_i)
            ADDR_W'(A_RAW):  rdata_o = raw_ext & view_keep;
            ADDR_W'(A_MASK): rdata_o = {{PAD_W{1'b0}}, mask_q};
            ADDR_W'(A_PEND): rdata_o = {{PAD_W{1'b0}}, pend};
            default:         rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign irq_o  = |pend;
endmodule

// File: rtl/aud_irq_gen.sv
module aud_irq_gen
    import aud_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_half_i,
    input  logic              tx_empty_i,
    input  logic              tx_busy_i,
    input  logic              tx_urun_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_waddr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic [ADDR_W-1:0] reg_raddr_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [STAT_W-1:0] raw_stat_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] mask_q;
    logic              clr_urun;

    aud_irq_src u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_i     (tx_half_i),
        .empty_i    (tx_empty_i),
        .busy_i     (tx_busy_i),
        .urun_i     (tx_urun_i),
        .clr_urun_i (clr_urun),
        .raw_o      (raw_q)
    );

    aud_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .waddr_i    (reg_waddr_i),
        .wdata_i    (reg_wdata_i),
        .raddr_i    (reg_raddr_i),
        .raw_i      (raw_q),
        .mask_o     (mask_q),
        .clr_urun_o (clr_urun),
        .rdata_o    (reg_rdata_o),
        .irq_o      (irq_o)
    );

    assign raw_stat_o = raw_q;
endmodule

// File: rtl/aud_irq_chk.sv
module aud_irq_chk
    import aud_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half,
    input logic              empty,
    input logic              busy,
    input logic              urun,
    input logic              wr,
    input logic [ADDR_W-1:0] waddr,
    input logic [DATA_W-1:0] wdata,
    input logic [STAT_W-1:0] raw,
    input logic [STAT_W-1:0] mask,
    input logic              irq
);
    logic clr_wr;
    assign clr_wr = wr && (waddr == ADDR_W'(A_CLR)) && wdata[BIT_URUN];

    p_req_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        half |=> raw[BIT_REQ]);
    p_req_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !half |=> !raw[BIT_REQ]);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !empty) |=> !raw[BIT_DONE]);
    p_urun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        urun |=> raw[BIT_URUN]);
    p_urun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[BIT_URUN] && !clr_wr) |=> raw[BIT_URUN]);
    p_urun_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !urun) |=> !raw[BIT_URUN]);
    p_clear_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && urun) |=> raw[BIT_URUN]);
    p_quiet_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0));
endmodule

bind aud_irq_gen aud_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .half  (tx_half_i),
    .empty (tx_empty_i),
    .busy  (tx_busy_i),
    .urun  (tx_urun_i),
    .wr    (reg_wr_i),
    .waddr (reg_waddr_i),
    .wdata (reg_wdata_i),
    .raw   (raw_q),
    .mask  (mask_q),
    .irq   (irq_o)
);

// File: tb/aud_irq_gen_bench.sv
module aud_irq_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half = 1'b0, empty = 1'b0, busy = 1'b1, urun = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] waddr = '0, raddr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] raw;
    logic       irq;
    int         total = 0, bad = 0;
    bit         done_flag = 1'b0;

    always #5 clk = ~clk;

    aud_irq_gen u_aud_irq_gen (
        .clk(clk), .rst_n(rst_n),
        .tx_half_i(half), .tx_empty_i(empty), .tx_busy_i(busy), .tx_urun_i(urun),
        .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
        .reg_raddr_i(raddr), .reg_rdata_o(rdata),
        .raw_stat_o(raw), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; waddr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        raddr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (2) step();
        check("R6 raw in reset", {5'b0, raw}, 8'h00);
        check("R6 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        step();
        reg_read(2'd1, d);
        check("R6 mask after reset", d, 8'h00);
        check("R6 irq after reset", {7'b0, irq}, 8'h00);
        check("R6 raw after reset", {5'b0, raw}, 8'h00);
    endtask

    task automatic t_request();
        half = 1'b1; step();
        check("R1 request set", {5'b0, raw}, 8'h01);
        half = 1'b0; step();
        check("R1 request cleared", {5'b0, raw}, 8'h00);
    endtask

    task automatic t_done();
        empty = 1'b1; busy = 1'b1; step();
        check("R2 empty but busy", {7'b0, raw[1]}, 8'h00);
        busy = 1'b0; step();
        check("R2 empty and idle", {7'b0, raw[1]}, 8'h01);
        empty = 1'b0; step();
        check("R2 not empty", {7'b0, raw[1]}, 8'h00);
        busy = 1'b1;
    endtask

    task automatic t_underrun();
        urun = 1'b1; step();
        urun = 1'b0;
        check("R3 underrun set", {7'b0, raw[2]}, 8'h01);
        repeat (3) step();
        check("R3 underrun sticky", {7'b0, raw[2]}, 8'h01);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        reg_write(2'd2, 8'h03);
        check("R4 clear without bit 2", {7'b0, raw[2]}, 8'h01);
        reg_write(2'd2, 8'h04);
        check("R4 clear with bit 2", {7'b0, raw[2]}, 8'h00);
        reg_read(2'd2, d);
        check("R8 clear address reads zero", d, 8'h00);
    endtask

    task automatic t_collide();
        urun = 1'b1;
        reg_write(2'd2, 8'h04);
        urun = 1'b0;
        check("R5 underrun wins over clear", {7'b0, raw[2]}, 8'h01);
        step();
        check("R5 still held", {7'b0, raw[2]}, 8'h01);
        reg_write(2'd2, 8'h04);
        check("R4 cleanup clear", {7'b0, raw[2]}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        empty = 1'b1; busy = 1'b0; step();
        reg_write(2'd1, 8'h02);
        check("R7 done enabled", {7'b0, irq}, 8'h01);
        reg_read(2'd1, d);
        check("R8 mask readback", d, 8'h02);
        reg_read(2'd3, d);
        check("R8 pending view", d, 8'h02);
        reg_read(2'd0, d);
        check("R8 raw view", d, 8'h02);
        reg_write(2'd1, 8'h01);
        check("R7 request enabled but low", {7'b0, irq}, 8'h00);
        half = 1'b1; step();
        check("R7 request raises irq", {7'b0, irq}, 8'h01);
        reg_read(2'd3, d);
        check("R8 pending masked", d, 8'h01);
        reg_write(2'd1, 8'h00);
        check("R7 mask zero", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        reg_write(2'd1, 8'h04);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd1, d);
        check("R9 raw write keeps mask", d, 8'h04);
        check("R9 raw write keeps status", {5'b0, raw}, 8'h03);
        reg_write(2'd3, 8'hFF);
        reg_read(2'd1, d);
        check("R9 pending write keeps mask", d, 8'h04);
        check("R9 pending write keeps irq", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_request();
        t_done();
        t_underrun();
        t_clear();
        t_collide();
        t_mask();
        t_ignored();
        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule